// File: doc/BRIEF.md
# SPI Master with Per-Frame Command Queue

This block is an SPI bus master. Every word queued for transmission carries its own 16-bit command next to its 16-bit payload. The command picks the chip-select lines for that frame and one of two frame-width settings. It also says whether chip select is held into the following frame and whether completing the frame should raise an end-of-queue flag. Because chip select can be held from one queued word to the next, several short frames can be chained into one longer transfer with no chip-select release between them.

The host writes the command half and the data half through separate strobes. A data write pushes one entry, made from the data half and the command. When the command strobe is asserted in the same cycle, that command is used; otherwise the last command written is used. Received frames enter a receive queue. A single pop strobe removes one entry, and the read value is always 32 bits wide with the frame in its low half. The serial side runs with SCLK idle low. MOSI changes after a falling edge, and MISO is sampled on each rising edge. Each SCLK half period is a fixed `DIV` clock cycles.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset, SCLK is low, all chip-select outputs are high, both queues are empty, the overflow, underflow and end-of-queue flags are low, and `rdata_o` reads zero.
- R2: A data write pushes one entry. Its command comes from `wcmd_i` if `wr_cmd_i` is set in the same cycle, and otherwise from the last command written alone. A command-only write pushes nothing.
- R3: Command bit 8 selects `fsz1_i` (1) or `fsz0_i` (0). The selected value is the frame width minus one, and values below 3 give a 4-bit frame. A frame produces exactly that many SCLK rising edges and sends data bits from bit (width-1) down to bit 0.
- R4: SCLK idles low and each half period lasts `DIV` clock cycles. MOSI does not change while SCLK is high, and MISO is sampled on the rising edges.
- R5: A completed frame is stored as the received bits in order, first-received as the most significant bit, zero-extended. `rdata_o[31:16]` is always zero.
- R6: A pop removes exactly one entry. A pop on an empty receive queue returns zero and sets a sticky underflow flag.
- R7: A data write while the transmit queue is full is discarded and sets a sticky overflow flag.
- R8: Command bits [5:0] name the chip-select lines, driven low for the frame. If bit 15 (continue) is 0, the lines return high for at least one half period after the frame. If it is 1, they stay low into the next frame.
- R9: If a frame with continue set ends while the transmit queue is empty, its chip-select lines stay low and SCLK stays low until a new entry is pushed.
- R10: Command bit 11 marks end of queue. When such a frame completes, `eoq_o` goes high and stays high until reset.
- R11: A frame that completes while the receive queue is full is dropped, and queued entries are unchanged.
- R12: Full and empty flags track the entry count of each 4-deep queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cmd_i | input | 1 | Command-half write strobe |
| wr_data_i | input | 1 | Data-half write strobe (pushes an entry) |
| wcmd_i | input | 16 | Command half |
| wdata_i | input | 16 | Data half |
| pop_i | input | 1 | Receive pop strobe |
| rdata_o | output | 32 | Receive head, zero-extended; zero when empty |
| fsz0_i | input | 4 | Width-minus-one, attribute set 0 |
| fsz1_i | input | 4 | Width-minus-one, attribute set 1 |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_ovf_o | output | 1 | Sticky push-on-full flag |
| rx_udf_o | output | 1 | Sticky pop-on-empty flag |
| eoq_o | output | 1 | Sticky end-of-queue flag |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 6 | Chip selects, active low |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong bit counter or width decode shows at the pins as an SCLK edge count or MOSI bit pattern that differs from the programmed width, and it is visible within the first frame. A chip-select sequencing fault shows as an extra chip-select release inside a chained transfer, or as a line left low after a plain frame, within one half period of the frame's end. Queue pointer or flag faults show on the next pop as a wrong value, a missing entry or a wrong empty state, and the overflow sweep also checks that exactly one of six back-to-back pushes was lost.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int DATA_W = 16;
  localparam int CMD_W  = 16;
  localparam int CS_N   = 6;
  localparam int FSZ_W  = 4;

  // host command half-word; positions matter to software
  typedef struct packed {
    logic       cont;   // 15
    logic [2:0] rsv0;
    logic       eoq;    // 11
    logic [1:0] rsv1;
    logic       attr;   // 8
    logic [1:0] rsv2;
    logic [CS_N-1:0] cs; // 5:0
  } cmd_t;

  // stored transmit entry, reserved bits dropped
  typedef struct packed {
    logic              cont;
    logic              eoq;
    logic              attr;
    logic [CS_N-1:0]   cs;
    logic [DATA_W-1:0] data;
  } tx_entry_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH, ENG_GAP} eng_state_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  tx_entry_t         tx_entry_i,
  output logic              tx_pop_o,
  input  logic [FSZ_W-1:0]  fsz0_i,
  input  logic [FSZ_W-1:0]  fsz1_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [CS_N-1:0]   cs_no,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              eoq_done_o
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [FSZ_W-1:0] FSZ_MIN = FSZ_W'(3);

  eng_state_e        state_q;
  logic [DCW-1:0]    cnt_q;
  logic [FSZ_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q, rx_q;
  logic [CS_N-1:0]   cs_q;
  logic              cont_q, eoq_q, sclk_q, rx_push_q, eoq_done_q;
  logic              tick;
  logic [FSZ_W-1:0]  fsz_raw, fsz_eff;

  assign tick     = (cnt_q == DCW'(DIV - 1));
  assign tx_pop_o = (state_q == ENG_IDLE) && tx_valid_i;
  assign fsz_raw  = tx_entry_i.attr ? fsz1_i : fsz0_i;
  assign fsz_eff  = (fsz_raw < FSZ_MIN) ? FSZ_MIN : fsz_raw;

  assign sclk_o     = sclk_q;
  assign mosi_o     = data_q[idx_q];
  assign cs_no      = ~cs_q;
  assign rx_push_o  = rx_push_q;
  assign rx_data_o  = rx_q;
  assign eoq_done_o = eoq_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ENG_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      data_q     <= '0;
      rx_q       <= '0;
      cs_q       <= '0;
      cont_q     <= 1'b0;
      eoq_q      <= 1'b0;
      sclk_q     <= 1'b0;
      rx_push_q  <= 1'b0;
      eoq_done_q <= 1'b0;
    end else begin
      rx_push_q  <= 1'b0;
      eoq_done_q <= 1'b0;
      if (state_q == ENG_IDLE || tick) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ENG_IDLE: if (tx_valid_i) begin
          data_q  <= tx_entry_i.data;
          idx_q   <= fsz_eff;
          cs_q    <= tx_entry_i.cs;  // replaces a held selection
          cont_q  <= tx_entry_i.cont;
          eoq_q   <= tx_entry_i.eoq;
          rx_q    <= '0;
          state_q <= ENG_LOW;
        end
        ENG_LOW: if (tick) begin
          sclk_q  <= 1'b1;
          rx_q    <= {rx_q[DATA_W-2:0], miso_i};
          state_q <= ENG_HIGH;
        end
        ENG_HIGH: if (tick) begin
          sclk_q <= 1'b0;
          if (idx_q == '0) begin
            rx_push_q  <= 1'b1;
            eoq_done_q <= eoq_q;
            if (cont_q) begin
              state_q <= ENG_IDLE;   // selection stays asserted
            end else begin
              cs_q    <= '0;
              state_q <= ENG_GAP;
            end
          end else begin
            idx_q   <= idx_q - 1'b1;
            state_q <= ENG_LOW;
          end
        end
        ENG_GAP: if (tick) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int DIV      = 2,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_cmd_i,
  input  logic        wr_data_i,
  input  logic [15:0] wcmd_i,
  input  logic [15:0] wdata_i,
  input  logic        pop_i,
  output logic [31:0] rdata_o,
  input  logic [3:0]  fsz0_i,
  input  logic [3:0]  fsz1_i,
  output logic        tx_full_o,
  output logic        tx_empty_o,
  output logic        rx_full_o,
  output logic        rx_empty_o,
  output logic        tx_ovf_o,
  output logic        rx_udf_o,
  output logic        eoq_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic [5:0]  cs_no,
  input  logic        miso_i
);
  localparam int TXW = $bits(tx_entry_t);

  cmd_t              cmd_hold_q, cmd_sel;
  tx_entry_t         tx_in, tx_head;
  logic [TXW-1:0]    tx_head_raw;
  logic              tx_pop, rx_push, eoq_done;
  logic [DATA_W-1:0] rx_data, rx_head;
  logic              ovf_q, udf_q, eoq_q;
  logic              unused_rsv;

  assign cmd_sel    = wr_cmd_i ? cmd_t'(wcmd_i) : cmd_hold_q;
  assign unused_rsv = ^{cmd_sel.rsv0, cmd_sel.rsv1, cmd_sel.rsv2};

  always_comb begin
    tx_in      = '0;
    tx_in.cont = cmd_sel.cont;
    tx_in.eoq  = cmd_sel.eoq;
    tx_in.attr = cmd_sel.attr;
    tx_in.cs   = cmd_sel.cs;
    tx_in.data = wdata_i;
  end

  assign tx_head = tx_entry_t'(tx_head_raw);

  spi_cmd_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data_i),
    .pop_i   (tx_pop),
    .wdata_i (tx_in),
    .rdata_o (tx_head_raw),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o)
  );

  spi_cmd_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .pop_i   (pop_i),
    .wdata_i (rx_data),
    .rdata_o (rx_head),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_o)
  );

  spi_cmd_engine #(.DIV(DIV)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_valid_i (!tx_empty_o),
    .tx_entry_i (tx_head),
    .tx_pop_o   (tx_pop),
    .fsz0_i     (fsz0_i),
    .fsz1_i     (fsz1_i),
    .miso_i     (miso_i),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .cs_no      (cs_no),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_data),
    .eoq_done_o (eoq_done)
  );

  assign rdata_o  = rx_empty_o ? 32'h0 : {16'h0, rx_head};
  assign tx_ovf_o = ovf_q;
  assign rx_udf_o = udf_q;
  assign eoq_o    = eoq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_hold_q <= '0;
      ovf_q      <= 1'b0;
      udf_q      <= 1'b0;
      eoq_q      <= 1'b0;
    end else begin
      if (wr_cmd_i)                ovf_q <= ovf_q;
      if (wr_cmd_i)                cmd_hold_q <= cmd_t'(wcmd_i);
      if (wr_data_i && tx_full_o)  ovf_q <= 1'b1;
      if (pop_i && rx_empty_o)     udf_q <= 1'b1;
      if (eoq_done)                eoq_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_data_i,
  input logic        pop_i,
  input logic [31:0] rdata_o,
  input logic        tx_full_o,
  input logic        tx_empty_o,
  input logic        rx_full_o,
  input logic        rx_empty_o,
  input logic        tx_ovf_o,
  input logic        rx_udf_o,
  input logic        eoq_o,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic [5:0]  cs_no
);
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:16] == 16'h0); // R5
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> rdata_o == 32'h0); // R6
  AST_UDF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && rx_empty_o) |=> rx_udf_o); // R6
  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_udf_o |=> rx_udf_o); // R6
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && tx_full_o) |=> tx_ovf_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o); // R7
  AST_TX_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o)); // R12
  AST_RX_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_o && rx_empty_o)); // R12
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R4
  AST_CS_STABLE_SCLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(cs_no)); // R8
  AST_EOQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_o |=> eoq_o); // R10
endmodule

bind spi_cmd_master spi_cmd_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_data_i  (wr_data_i),
  .pop_i      (pop_i),
  .rdata_o    (rdata_o),
  .tx_full_o  (tx_full_o),
  .tx_empty_o (tx_empty_o),
  .rx_full_o  (rx_full_o),
  .rx_empty_o (rx_empty_o),
  .tx_ovf_o   (tx_ovf_o),
  .rx_udf_o   (rx_udf_o),
  .eoq_o      (eoq_o),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no)
);

// File: tb/tb_spi_cmd_master.sv
`timescale 1ns/1ps
module tb_spi_cmd_master;
  localparam int DIV = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_cmd_i = 1'b0, wr_data_i = 1'b0, pop_i = 1'b0;
  logic [15:0] wcmd_i = '0, wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  fsz0_i = 4'd7, fsz1_i = 4'd7;
  logic        tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;
  logic        tx_ovf_o, rx_udf_o, eoq_o, sclk_o, mosi_o, miso_i;
  logic [5:0]  cs_no;

  spi_cmd_master #(.DIV(DIV)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_cmd_i(wr_cmd_i), .wr_data_i(wr_data_i),
    .wcmd_i(wcmd_i), .wdata_i(wdata_i), .pop_i(pop_i), .rdata_o(rdata_o),
    .fsz0_i(fsz0_i), .fsz1_i(fsz1_i), .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o),
    .rx_full_o(rx_full_o), .rx_empty_o(rx_empty_o), .tx_ovf_o(tx_ovf_o),
    .rx_udf_o(rx_udf_o), .eoq_o(eoq_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .cs_no(cs_no), .miso_i(miso_i)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  // pin monitor, sole writer of its counters
  int cyc = 0, rise_cnt = 0, fall_cnt = 0, last_rise = 0, last_fall = 0, mosi_bad = 0;
  int cs_fall_cnt [6];
  int cs_rise_cnt [6];
  logic [31:0] m_cap = '0;
  logic sclk_p = 1'b0, mosi_p = 1'b0;
  logic [5:0] cs_p = 6'h3f;
  // slave model, written only by the stimulus
  logic [15:0] s_word = '0;
  int fall_base = 0;
  logic [3:0] s_idx;

  initial for (int i = 0; i < 6; i++) begin cs_fall_cnt[i] = 0; cs_rise_cnt[i] = 0; end

  assign s_idx  = 4'(15 - (fall_cnt - fall_base));
  assign miso_i = s_word[s_idx];

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (sclk_o && !sclk_p) begin
      rise_cnt  <= rise_cnt + 1;
      m_cap     <= {m_cap[30:0], mosi_o};
      last_rise <= cyc;
    end
    if (!sclk_o && sclk_p) begin
      fall_cnt  <= fall_cnt + 1;
      last_fall <= cyc;
    end
    if (sclk_o && sclk_p && (mosi_o != mosi_p)) mosi_bad <= mosi_bad + 1;
    for (int i = 0; i < 6; i++) begin
      if (!cs_no[i] && cs_p[i]) cs_fall_cnt[i] <= cs_fall_cnt[i] + 1;
      if (cs_no[i] && !cs_p[i]) cs_rise_cnt[i] <= cs_rise_cnt[i] + 1;
    end
    sclk_p <= sclk_o;
    mosi_p <= mosi_o;
    cs_p   <= cs_no;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic with_cmd, input logic [15:0] c, input logic [15:0] d);
    wr_cmd_i = with_cmd; wcmd_i = c; wr_data_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_cmd_i = 1'b0; wr_data_i = 1'b0;
  endtask

  task automatic pop_read(output logic [31:0] v);
    v = rdata_o;
    pop_i = 1'b1;
    @(negedge clk_i);
    pop_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!tx_empty_o) @(negedge clk_i);
    repeat (40 * DIV + 8) @(negedge clk_i);
  endtask

  function automatic logic [15:0] mk_cmd(input logic cont, input logic eoq,
                                         input logic attr, input logic [5:0] cs);
    return {cont, 3'b0, eoq, 2'b0, attr, 2'b0, cs};
  endfunction

  function automatic logic [31:0] lowbits(input logic [31:0] v, input int w);
    return v & ((32'h1 << w) - 1);
  endfunction

  task automatic run_frame(input int w, input logic sel, input logic [15:0] d,
                           input logic [15:0] sw);
    int li, rb, cf, cr;
    logic [31:0] v;
    li = w % 6;
    if (sel) begin fsz1_i = 4'(w - 1); fsz0_i = (w == 16) ? 4'd3 : 4'd15; end
    else     begin fsz0_i = 4'(w - 1); fsz1_i = (w == 16) ? 4'd3 : 4'd15; end
    s_word = sw; fall_base = fall_cnt; rb = rise_cnt;
    cf = cs_fall_cnt[li]; cr = cs_rise_cnt[li];
    push(1'b1, mk_cmd(1'b0, 1'b0, sel, 6'(1 << li)), d);
    wait_done();
    chk("R3 edge count", 32'(rise_cnt - rb), 32'(w));
    chk("R3 mosi bits", lowbits(m_cap, w), lowbits({16'h0, d}, w));
    chk("R4 half period", 32'(last_fall - last_rise), 32'(DIV));
    chk("R8 cs asserted once", 32'(cs_fall_cnt[li] - cf), 32'd1);
    chk("R8 cs released", {26'h0, cs_no}, 32'h3f);
    chk("R8 cs release count", 32'(cs_rise_cnt[li] - cr), 32'd1);
    pop_read(v);
    chk("R5 rx value", v, {16'h0, sw} >> (16 - w));
    chk("R6 rx empty after pop", {31'h0, rx_empty_o}, 32'd1);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    int rb, cr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 sclk", {31'h0, sclk_o}, 32'd0);
    chk("R1 cs", {26'h0, cs_no}, 32'h3f);
    chk("R1 empties", {30'h0, tx_empty_o, rx_empty_o}, 32'd3);
    chk("R1 flags", {27'h0, tx_full_o, rx_full_o, tx_ovf_o, rx_udf_o, eoq_o}, 32'd0);
    chk("R1 rdata", rdata_o, 32'd0);

    // R3 R4 R5 R8 sweep of widths, attribute selects and patterns
    for (int w = 4; w <= 16; w++)
      for (int s = 0; s < 2; s++) begin
        run_frame(w, s[0], 16'hA5C3 ^ 16'(w * 16'h1111), 16'h3C96 ^ 16'(w * 16'h0707));
        run_frame(w, s[0], ~(16'h5A17 + 16'(w)), 16'hF00F ^ 16'(s * 16'h1248));
      end
    chk("R4 mosi steady while sclk high", 32'(mosi_bad), 32'd0);
    chk("R10 eoq not set yet", {31'h0, eoq_o}, 32'd0);
    chk("R7 no overflow yet", {31'h0, tx_ovf_o}, 32'd0);

    // R3 clamp: field 1 gives 4 bits
    fsz0_i = 4'd1; s_word = 16'h9000; fall_base = fall_cnt; rb = rise_cnt;
    push(1'b1, mk_cmd(1'b0, 1'b0, 1'b0, 6'h01), 16'h000B);
    wait_done();
    chk("R3 clamped width", 32'(rise_cnt - rb), 32'd4);
    pop_read(v);
    chk("R5 clamped rx", v, 32'h9);

    // R2 held command: command-only write then data-only push
    fsz1_i = 4'd5; rb = rise_cnt; s_word = 16'h0; fall_base = fall_cnt;
    wr_cmd_i = 1'b1; wcmd_i = mk_cmd(1'b0, 1'b0, 1'b1, 6'h20);
    @(negedge clk_i);
    wr_cmd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R2 command write alone pushes nothing", {31'h0, tx_empty_o}, 32'd1);
    chk("R2 no bus activity", 32'(rise_cnt - rb), 32'd0);
    cr = cs_fall_cnt[5];
    push(1'b0, 16'h0, 16'h002D);
    wait_done();
    chk("R2 held cs line", 32'(cs_fall_cnt[5] - cr), 32'd1);
    chk("R2 held attr width", 32'(rise_cnt - rb), 32'd6);
    chk("R2 data bits", lowbits(m_cap, 6), 32'h2D);
    pop_read(v);

    // R8 chained frames with continue, no release between
    fsz0_i = 4'd7; s_word = 16'hC3A5; fall_base = fall_cnt; rb = rise_cnt; cr = cs_rise_cnt[0];
    push(1'b1, mk_cmd(1'b1, 1'b0, 1'b0, 6'h01), 16'h00E7);
    push(1'b1, mk_cmd(1'b0, 1'b0, 1'b0, 6'h01), 16'h0019);
    wait_done();
    chk("R8 chain edges", 32'(rise_cnt - rb), 32'd16);
    chk("R8 chain mosi", lowbits(m_cap, 16), 32'hE719);
    chk("R8 single release", 32'(cs_rise_cnt[0] - cr), 32'd1);
    pop_read(v); chk("R5 chain first", v, 32'hC3);
    pop_read(v); chk("R5 chain second", v, 32'hA5);

    // R8 plain frames back to back release between them
    cr = cs_rise_cnt[0];
    push(1'b1, mk_cmd(1'b0, 1'b0, 1'b0, 6'h01), 16'h0011);
    push(1'b1, mk_cmd(1'b0, 1'b0, 1'b0, 6'h01), 16'h0022);
    wait_done();
    chk("R8 two releases", 32'(cs_rise_cnt[0] - cr), 32'd2);
    pop_read(v); pop_read(v);

    // R9 continue with empty queue holds select, bus idle
    rb = rise_cnt; cr = cs_rise_cnt[2];
    push(1'b1, mk_cmd(1'b1, 1'b0, 1'b0, 6'h04), 16'h0081);
    wait_done();
    repeat (50) @(negedge clk_i);
    chk("R9 cs held", {26'h0, cs_no}, 32'h3b);
    chk("R9 sclk idle", {31'h0, sclk_o}, 32'd0);
    chk("R9 no extra edges", 32'(rise_cnt - rb), 32'd8);
    // R10 closing frame marks end of queue
    push(1'b1, mk_cmd(1'b0, 1'b1, 1'b0, 6'h04), 16'h0042);
    wait_done();
    chk("R9 released after close", 32'(cs_rise_cnt[2] - cr), 32'd1);
    chk("R10 eoq set", {31'h0, eoq_o}, 32'd1);
    pop_read(v); pop_read(v);

    // R7 R11 R12 six pushes, one lost; five frames, one dropped at RX
    fsz0_i = 4'd15; s_word = 16'hB66D; fall_base = fall_cnt; rb = rise_cnt;
    for (int k = 0; k < 6; k++) push(1'b1, mk_cmd(1'b0, 1'b0, 1'b0, 6'h02), 16'(k));
    chk("R12 tx full", {31'h0, tx_full_o}, 32'd1);
    chk("R7 overflow flag", {31'h0, tx_ovf_o}, 32'd1);
    wait_done();
    chk("R7 five frames sent", 32'(rise_cnt - rb), 32'd80);
    chk("R12 rx full", {31'h0, rx_full_o}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      pop_read(v);
      chk("R11 kept entry", v, 32'hB66D);
    end
    chk("R11 fifth frame dropped", {31'h0, rx_empty_o}, 32'd1);
    chk("R6 no underflow yet", {31'h0, rx_udf_o}, 32'd0);
    pop_read(v);
    chk("R6 empty pop value", v, 32'd0);
    chk("R6 underflow flag", {31'h0, rx_udf_o}, 32'd1);
    chk("R12 tx empty", {31'h0, tx_empty_o}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule